// File: doc/BRIEF.md
# MSI Snooping Cache-Line Coherence Controller

This block keeps the coherence state of every line of one cache that shares a snooping broadcast bus with other caches. Each line is Invalid, Shared or Modified. Processor reads and writes are checked against the line's state. Reads and writes that can be served locally complete in the same cycle. Accesses that need the bus raise a bus request and stall until the bus grants it. Transactions snooped from other caches move the line to a weaker state and request a flush when this cache holds the only valid copy.

The state is stored per line in a small, directly indexed array. Reads of that array and all decisions are combinational. The new state is written on the clock edge. When a snoop and a processor access hit the same line in the same cycle, the snoop is applied first. The processor access is then judged against the state the snoop leaves behind, which keeps the order seen on the shared bus.

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, so the first read of any line raises a bus read request.
- R2: A read of an Invalid line raises busReqValid with busReqExcl=0. When it is granted, the line becomes Shared.
- R3: A read of a Shared or Modified line asserts cpuReady in the same cycle, raises no bus request and leaves the state unchanged.
- R4: A write to an Invalid or Shared line raises busReqValid with busReqExcl=1. When it is granted, the line becomes Modified.
- R5: A write to a Modified line asserts cpuReady in the same cycle and raises no bus request.
- R6: A snooped read (snpValid=1, snpExcl=0) of a Modified line asserts flushValid in that cycle and moves the line to Shared.
- R7: A snooped read of a Shared or Invalid line asserts no flush and leaves the state unchanged.
- R8: A snooped read-exclusive (snpExcl=1) of a Shared line invalidates it without a flush. On a Modified line it asserts flushValid and invalidates the line.
- R9: When snpIdx equals cpuIdx in one cycle, the snoop is applied first, and the processor access is evaluated against the state after the snoop.
- R10: While a bus request is raised and busGrant is low, cpuReady stays low and the line state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Processor access valid |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuIdx | input | IDX_W | Line index of the processor access |
| cpuReady | output | 1 | Access may proceed this cycle |
| busReqValid | output | 1 | Bus transaction requested |
| busReqExcl | output | 1 | 1 = read-exclusive, 0 = read (valid with busReqValid) |
| busReqIdx | output | IDX_W | Line index of the requested transaction |
| busGrant | input | 1 | Bus granted to this cache this cycle |
| snpValid | input | 1 | Snooped transaction valid |
| snpExcl | input | 1 | 1 = snooped read-exclusive, 0 = snooped read |
| snpIdx | input | IDX_W | Line index of the snooped transaction |
| flushValid | output | 1 | Line must be written back this cycle |
| flushIdx | output | IDX_W | Line index to flush |

## Verification
A line in the wrong state shows at the ports at the next access to that line, in the same cycle as that access. A line wrongly left Invalid or Shared raises an unexpected bus request. A line wrongly held as Modified suppresses a needed request, or flushes on a snoop that should be silent. The bench keeps its own copy of every line's state, worked out from the rules above. It sweeps every line through every state and every operation, then runs a long pseudo-random mix. Same-line collisions are frequent in that mix, so an error in state or ordering is caught within a few accesses to the affected line.

// File: rtl/msi_pkg.sv
package msi_pkg;

  typedef enum logic [1:0] {
    LINE_I = 2'd0,
    LINE_S = 2'd1,
    LINE_M = 2'd2
  } lineStateT;

  // strobes from control to the state array
  typedef struct packed {
    logic      cpuWrEn;
    lineStateT cpuNext;
    logic      snpWrEn;
    lineStateT snpNext;
  } stateStrobesT;

endpackage

// File: rtl/msi_state_array.sv
module msi_state_array
  import msi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  stateStrobesT         strobes,
  input  logic [IDX_W-1:0]     cpuIdx,
  input  logic [IDX_W-1:0]     snpIdx,
  output lineStateT            cpuState,
  output lineStateT            snpState
);

  lineStateT lineQ [NUM_LINES];

  // processor write takes precedence: it was evaluated after the snoop
  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    always_ff @(posedge clk) begin
      if (!rstN) begin
        lineQ[g] <= LINE_I;
      end else if (strobes.cpuWrEn && (cpuIdx == IDX_W'(g))) begin
        lineQ[g] <= strobes.cpuNext;
      end else if (strobes.snpWrEn && (snpIdx == IDX_W'(g))) begin
        lineQ[g] <= strobes.snpNext;
      end
    end
  end

  assign cpuState = lineQ[cpuIdx];
  assign snpState = lineQ[snpIdx];

endmodule

// File: rtl/msi_ctl.sv
module msi_ctl
  import msi_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             cpuReq,
  input  logic             cpuWrite,
  input  logic [IDX_W-1:0] cpuIdx,
  input  logic             busGrant,
  input  logic             snpValid,
  input  logic             snpExcl,
  input  logic [IDX_W-1:0] snpIdx,
  input  lineStateT        cpuState,
  input  lineStateT        snpState,
  output logic             cpuReady,
  output logic             busReqValid,
  output logic             busReqExcl,
  output logic             flushValid,
  output stateStrobesT     strobes
);

  lineStateT snpNext;
  lineStateT effState;
  logic      snpOnM;
  logic      sameLine;
  logic      needBus;

  // snoop side
  always_comb begin
    snpOnM = (snpState == LINE_M);
    if (snpExcl)     snpNext = LINE_I;
    else if (snpOnM) snpNext = LINE_S;
    else             snpNext = snpState;
  end

  assign flushValid = snpValid && snpOnM;

  // processor side sees the post-snoop state of a colliding line
  assign sameLine = snpValid && (snpIdx == cpuIdx);
  assign effState = sameLine ? snpNext : cpuState;

  always_comb begin
    if (cpuWrite) needBus = (effState != LINE_M);
    else          needBus = (effState == LINE_I);
  end

  assign busReqValid = cpuReq && needBus;
  assign busReqExcl  = busReqValid && cpuWrite;
  assign cpuReady    = cpuReq && (!needBus || busGrant);

  always_comb begin
    strobes.snpWrEn = snpValid && (snpNext != snpState);
    strobes.snpNext = snpNext;
    strobes.cpuWrEn = cpuReady;
    if (cpuWrite)                 strobes.cpuNext = LINE_M;
    else if (effState == LINE_I)  strobes.cpuNext = LINE_S;
    else                          strobes.cpuNext = effState;
  end

endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
  import msi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuReq,
  input  logic             cpuWrite,
  input  logic [IDX_W-1:0] cpuIdx,
  output logic             cpuReady,
  output logic             busReqValid,
  output logic             busReqExcl,
  output logic [IDX_W-1:0] busReqIdx,
  input  logic             busGrant,
  input  logic             snpValid,
  input  logic             snpExcl,
  input  logic [IDX_W-1:0] snpIdx,
  output logic             flushValid,
  output logic [IDX_W-1:0] flushIdx
);

  stateStrobesT strobes;
  lineStateT    cpuState;
  lineStateT    snpState;

  msi_state_array #(
    .NUM_LINES(NUM_LINES),
    .IDX_W    (IDX_W)
  ) uArray (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .cpuIdx  (cpuIdx),
    .snpIdx  (snpIdx),
    .cpuState(cpuState),
    .snpState(snpState)
  );

  msi_ctl #(
    .IDX_W(IDX_W)
  ) uCtl (
    .cpuReq     (cpuReq),
    .cpuWrite   (cpuWrite),
    .cpuIdx     (cpuIdx),
    .busGrant   (busGrant),
    .snpValid   (snpValid),
    .snpExcl    (snpExcl),
    .snpIdx     (snpIdx),
    .cpuState   (cpuState),
    .snpState   (snpState),
    .cpuReady   (cpuReady),
    .busReqValid(busReqValid),
    .busReqExcl (busReqExcl),
    .flushValid (flushValid),
    .strobes    (strobes)
  );

  assign busReqIdx = cpuIdx;
  assign flushIdx  = snpIdx;

endmodule

// File: rtl/msi_line_ctrl_chk.sv
module msi_line_ctrl_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             cpuReq,
  input logic             cpuWrite,
  input logic [IDX_W-1:0] cpuIdx,
  input logic             cpuReady,
  input logic             busReqValid,
  input logic             busReqExcl,
  input logic             busGrant,
  input logic             snpValid,
  input logic [IDX_W-1:0] snpIdx,
  input logic             flushValid
);

  // last completed access, to check that a repeat hits locally
  logic             doneQ;
  logic             doneWrQ;
  logic [IDX_W-1:0] doneIdxQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneQ    <= 1'b0;
      doneWrQ  <= 1'b0;
      doneIdxQ <= '0;
    end else begin
      doneQ    <= cpuReq && cpuReady;
      doneWrQ  <= cpuWrite;
      doneIdxQ <= cpuIdx;
    end
  end

  assert_req_from_cpu_R2: assert property (@(posedge clk) disable iff (!rstN)
    busReqValid |-> cpuReq);

  assert_stall_no_grant_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busReqValid && !busGrant) |-> !cpuReady);

  assert_excl_on_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    busReqValid |-> (busReqExcl == cpuWrite));

  assert_flush_on_snoop_R6: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |-> snpValid);

  assert_repeat_hits_R3: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && cpuReq && (cpuIdx == doneIdxQ) && !(snpValid && snpIdx == cpuIdx)
     && (!cpuWrite || doneWrQ)) |-> (cpuReady && !busReqValid));

  // R5: a repeated write to a line just written raises no bus request
  assert_rewrite_local_R5: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && doneWrQ && cpuReq && cpuWrite && (cpuIdx == doneIdxQ)
     && !(snpValid && snpIdx == cpuIdx)) |-> !busReqValid);

endmodule

bind msi_line_ctrl msi_line_ctrl_chk #(.IDX_W(IDX_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .cpuReq     (cpuReq),
  .cpuWrite   (cpuWrite),
  .cpuIdx     (cpuIdx),
  .cpuReady   (cpuReady),
  .busReqValid(busReqValid),
  .busReqExcl (busReqExcl),
  .busGrant   (busGrant),
  .snpValid   (snpValid),
  .snpIdx     (snpIdx),
  .flushValid (flushValid)
);

// File: tb/sim_msi_line_ctrl.sv
`timescale 1ns/1ps
module sim_msi_line_ctrl;

  localparam int NL = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuReq = 1'b0, cpuWrite = 1'b0, busGrant = 1'b0;
  logic snpValid = 1'b0, snpExcl = 1'b0;
  logic [IW-1:0] cpuIdx = '0, snpIdx = '0;
  logic cpuReady, busReqValid, busReqExcl, flushValid;
  logic [IW-1:0] busReqIdx, flushIdx;

  int total = 0;
  int bad = 0;
  int ms [NL];        // 0 = I, 1 = S, 2 = M
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;   // 125 MHz

  msi_line_ctrl #(.NUM_LINES(NL)) u0 (
    .clk(clk), .rstN(rstN),
    .cpuReq(cpuReq), .cpuWrite(cpuWrite), .cpuIdx(cpuIdx), .cpuReady(cpuReady),
    .busReqValid(busReqValid), .busReqExcl(busReqExcl), .busReqIdx(busReqIdx),
    .busGrant(busGrant),
    .snpValid(snpValid), .snpExcl(snpExcl), .snpIdx(snpIdx),
    .flushValid(flushValid), .flushIdx(flushIdx)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input logic rq, input logic wr, input int idx, input logic gr,
                      input logic sv, input logic sx, input int si);
    int s, sNew, cs, nb;
    logic expRdy, expFl;
    string tagC, tagF;
    @(negedge clk);
    cpuReq = rq; cpuWrite = wr; cpuIdx = IW'(idx); busGrant = gr;
    snpValid = sv; snpExcl = sx; snpIdx = IW'(si);
    #1;
    s = ms[si];
    sNew = sx ? 0 : ((s == 2) ? 1 : s);
    expFl = sv && (s == 2);
    cs = (sv && si == idx) ? sNew : ms[idx];
    nb = rq && (wr ? (cs != 2) : (cs == 0));
    expRdy = rq && (!nb || gr);
    if (sv && si == idx && rq)      tagC = "R9";
    else if (nb && !gr)             tagC = "R10";
    else if (!wr && cs == 0)        tagC = "R2";
    else if (!wr)                   tagC = "R3";
    else if (cs == 2)               tagC = "R5";
    else                            tagC = "R4";
    if (!sv)        tagF = "R6";
    else if (sx)    tagF = "R8";
    else if (s == 2) tagF = "R6";
    else            tagF = "R7";
    chk(tagC, "busReqValid", busReqValid, nb[0]);
    chk(tagC, "busReqExcl", busReqExcl, nb[0] && wr);
    chk(tagC, "cpuReady", cpuReady, expRdy);
    chk(tagF, "flushValid", flushValid, expFl);
    if (sv) ms[si] = sNew;
    if (expRdy) ms[idx] = wr ? 2 : ((cs == 0) ? 1 : cs);
  endtask

  initial begin
    for (int i = 0; i < NL; i++) ms[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: every line starts Invalid
    for (int l = 0; l < NL; l++) begin
      @(negedge clk);
      cpuReq = 1; cpuWrite = 0; cpuIdx = IW'(l); busGrant = 0; snpValid = 0;
      #1;
      chk("R1", "busReqValid", busReqValid, 1'b1);
      chk("R1", "cpuReady", cpuReady, 1'b0);
    end
    // directed sweep through every state and operation on every line
    for (int l = 0; l < NL; l++) begin
      step(1, 0, l, 0, 0, 0, 0);   // R10 stall
      step(1, 0, l, 1, 0, 0, 0);   // R2 -> S
      step(1, 0, l, 0, 0, 0, 0);   // R3 hit on S
      step(0, 0, l, 0, 1, 0, l);   // R7 snoop read on S
      step(1, 0, l, 0, 0, 0, 0);   // R7 state kept
      step(1, 1, l, 0, 0, 0, 0);   // R10 write stall
      step(1, 1, l, 1, 0, 0, 0);   // R4 S -> M
      step(1, 1, l, 0, 0, 0, 0);   // R5
      step(1, 0, l, 0, 0, 0, 0);   // R3 hit on M
      step(0, 0, l, 0, 1, 0, l);   // R6 flush, -> S
      step(1, 1, l, 0, 0, 0, 0);   // S needs rdx
      step(1, 1, l, 1, 0, 0, 0);   // -> M
      step(0, 0, l, 0, 1, 1, l);   // R8 flush, -> I
      step(1, 0, l, 0, 0, 0, 0);   // I again
      step(1, 0, l, 1, 0, 0, 0);   // -> S
      step(0, 0, l, 0, 1, 1, l);   // R8 no flush, -> I
      step(0, 0, l, 0, 1, 0, l);   // R7 snoop on I
      step(1, 1, l, 1, 0, 0, 0);   // I -> M via R4
      step(1, 1, l, 0, 1, 0, l);   // R9 snoop first, write needs rdx
      step(1, 1, l, 1, 1, 0, l);   // R9 granted -> M
      step(1, 0, l, 0, 1, 1, l);   // R9 flush, read then misses
    end
    // pseudo-random mix, biased toward same-line collisions
    for (int n = 0; n < 6000; n++) begin
      logic rq, wr, gr, sv, sx;
      int idx, si;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rq  = lfsr[0] | lfsr[1];
      wr  = lfsr[2];
      gr  = lfsr[3];
      sv  = lfsr[4] & lfsr[5];
      sx  = lfsr[6];
      idx = int'(lfsr[9:7]) & 3;
      si  = lfsr[10] ? idx : (int'(lfsr[13:11]) & 3);
      step(rq, wr, idx, gr, sv, sx, si);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule